// File: doc/BRIEF.md
# Random Number Generator Control Front End

This block is the register-mapped face of a random number generator. Software talks to it over a simple 32-bit bus with separate read and write strobes. The bus carries an identification word, a command register for starting operations and clearing the interrupt, and a control register with mask and auto-seed flags. It also carries a status word and a data port that returns random words.

Seeding and self-test are separate operations. Each one moves from idle to running when its start bit is written, and reaches done after a fixed number of clock cycles. Reaching done raises the active-high interrupt unless completions are masked. A built-in 32-bit linear feedback shift register stands in for the entropy source and advances one step on each data read.

Top module: `rng_ctl_top`

## Requirements
- R1: A read of offset 0x00 returns 0x1000_0240: type 1 in bits 31:28, major 2 in bits 15:8, minor 0x40 in bits 7:0.
- R2: A read of offset 0x04 returns bit 1 while seeding runs and bit 0 while self-test runs, with every other bit zero.
- R3: Writing offset 0x04 with bit 1 (seed) or bit 0 (self-test) set puts that operation in running for exactly SEED_CYCLES (16) or TEST_CYCLES (8) clock cycles, after which it becomes done. A new start while running restarts the full count.
- R4: A write to offset 0x08 stores bit 6 (error mask), bit 5 (done mask) and bit 4 (auto-seed) from the write data. A read returns those bits in place and zero in every other bit.
- R5: A read of offset 0x0C returns 5 in bits 15:12, 5 in bits 11:8, a constant 1 in bit 6, seed-done in bit 5 and self-test-done in bit 4. The idle value is 0x5541.
- R6: Status bit 1 (busy) is set while either operation runs, and otherwise status bit 0 (ready) is set. Exactly one of the two is set.
- R7: `irq` goes high in the cycle after an operation reaches done if the done-mask bit is clear at that moment. When the done-mask bit is set, completion leaves `irq` unchanged. `irq` is low after hardware reset.
- R8: A command write with bit 5 or bit 4 set drives `irq` low. A completion in the same cycle takes priority and keeps it high.
- R9: A command write with bit 6 set returns both operations to idle and clears all control bits. It leaves `irq` as it was. Start bits in the same write still take effect.
- R10: A read of offset 0x14 returns the current generator word and then advances it. The next word is the old word shifted left by one, with the XOR of bits 31, 21, 1 and 0 entering at bit 0. Hardware reset loads 0xACE1_2D5F, and the word is never zero.
- R11: Reads of offsets other than 0x00, 0x04, 0x08, 0x0C and 0x14 return zero. Writes to offsets other than 0x04 and 0x08 change nothing.
- R12: `rd_data` is loaded at the clock edge where `rd_en` is high and holds its value otherwise. It is zero after hardware reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| addr | input | ADDR_W (8) | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; also advances the generator when reading 0x14 |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Completion interrupt, active high |

## Verification
The sequencers are started one at a time, both together, and again while they are already running. These runs separate a correct cycle count from an off-by-one, and a counter reload from a counter that is ignored. The interrupt is raised with the mask clear and with it set, and is cleared through each of the two clear bits. This shows that both clear paths work and that the mask is sampled at completion. Soft reset is issued alone, with a start bit in the same write, and with the interrupt pending, which exposes the wrong priority between reset, start and interrupt. Data reads are followed by a hardware reset so that stepping and seed reload are both seen.

// File: rtl/rng_ctl_pkg.sv
package rng_ctl_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RUN  = 2'd1,
    OP_DONE = 2'd2
  } op_state_e;

  // Register offsets (byte addresses)
  localparam int OFS_VER  = 'h00;
  localparam int OFS_CMD  = 'h04;
  localparam int OFS_CTL  = 'h08;
  localparam int OFS_STAT = 'h0C;
  localparam int OFS_DATA = 'h14;

  // Command bits; bit 0 and bit 1 double as the operation index
  localparam int CMD_TEST    = 0;
  localparam int CMD_SEED    = 1;
  localparam int CMD_CLR_IRQ = 4;
  localparam int CMD_CLR_ERR = 5;
  localparam int CMD_SW_RST  = 6;

  // Control bits
  localparam int CTL_AUTO  = 4;
  localparam int CTL_MDONE = 5;
  localparam int CTL_MERR  = 6;

  localparam logic [31:0] ID_WORD = 32'h1000_0240;

  // One step of a Fibonacci shift register, taps 32,22,2,1
  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [31:0] status_word(input logic seed_done,
                                              input logic test_done,
                                              input logic busy);
    logic [31:0] w;
    w        = '0;
    w[15:12] = 4'd5;
    w[11:8]  = 4'd5;
    w[6]     = 1'b1;
    w[5]     = seed_done;
    w[4]     = test_done;
    w[1]     = busy;
    w[0]     = ~busy;
    return w;
  endfunction

endpackage

// File: rtl/rng_op_seq.sv
module rng_op_seq
  import rng_ctl_pkg::*;
#(
  parameter int CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      clr,
  output op_state_e state_o,
  output logic      done_evt_o
);
  localparam int CNT_W = ($clog2(CYCLES) < 1) ? 1 : $clog2(CYCLES);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  op_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             finish;

  assign finish = (st_q == OP_RUN) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OP_IDLE;
      cnt_q <= '0;
    end else if (start) begin
      st_q  <= OP_RUN;
      cnt_q <= LOAD;
    end else if (clr) begin
      st_q  <= OP_IDLE;
      cnt_q <= '0;
    end else if (st_q == OP_RUN) begin
      if (finish) st_q <= OP_DONE;
      else        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign state_o    = st_q;
  assign done_evt_o = finish && !start && !clr;
endmodule

// File: rtl/rng_lfsr.sv
module rng_lfsr
  import rng_ctl_pkg::*;
#(
  parameter logic [31:0] SEED = 32'hACE1_2D5F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [31:0] word_o
);
  localparam logic [31:0] SAFE_SEED = (SEED == '0) ? 32'h1 : SEED;

  logic [31:0] s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   s_q <= SAFE_SEED;
    else if (adv) s_q <= lfsr_step(s_q);
  end

  assign word_o = s_q;
endmodule

// File: rtl/rng_irq_gen.sv
module rng_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic done_evt,
  input  logic mask_done,
  input  logic clr,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      irq_o <= 1'b0;
    else if (done_evt && !mask_done) irq_o <= 1'b1;
    else if (clr)                    irq_o <= 1'b0;
  end
endmodule

// File: rtl/rng_ctl_top.sv
module rng_ctl_top
  import rng_ctl_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          SEED_CYCLES = 16,
  parameter int          TEST_CYCLES = 8,
  parameter logic [31:0] LFSR_SEED   = 32'hACE1_2D5F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam int N_OPS = 2;  // index 0: self-test, index 1: seed

  // Address decode
  logic sel_ver, sel_cmd, sel_ctl, sel_stat, sel_data;
  assign sel_ver  = (addr == ADDR_W'(OFS_VER));
  assign sel_cmd  = (addr == ADDR_W'(OFS_CMD));
  assign sel_ctl  = (addr == ADDR_W'(OFS_CTL));
  assign sel_stat = (addr == ADDR_W'(OFS_STAT));
  assign sel_data = (addr == ADDR_W'(OFS_DATA));

  // Named internal events
  logic cmd_wr, ctl_wr, soft_rst, clr_irq, data_rd;
  logic [N_OPS-1:0] op_go;
  logic [N_OPS-1:0] op_done;
  logic [N_OPS-1:0] op_run;
  logic [N_OPS-1:0] op_fin;
  logic             busy_any;

  assign cmd_wr   = wr_en && sel_cmd;
  assign ctl_wr   = wr_en && sel_ctl;
  assign soft_rst = cmd_wr && wr_data[CMD_SW_RST];
  assign clr_irq  = cmd_wr && (wr_data[CMD_CLR_ERR] || wr_data[CMD_CLR_IRQ]);
  assign data_rd  = rd_en && sel_data;

  op_state_e op_st [N_OPS];

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    assign op_go[g] = cmd_wr && wr_data[g];
    rng_op_seq #(
      .CYCLES((g == CMD_TEST) ? TEST_CYCLES : SEED_CYCLES)
    ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (op_go[g]),
      .clr       (soft_rst),
      .state_o   (op_st[g]),
      .done_evt_o(op_done[g])
    );
    assign op_run[g] = (op_st[g] == OP_RUN);
    assign op_fin[g] = (op_st[g] == OP_DONE);
  end

  assign busy_any = |op_run;

  // Control flags
  logic mask_err_q, mask_done_q, auto_seed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_err_q  <= 1'b0;
      mask_done_q <= 1'b0;
      auto_seed_q <= 1'b0;
    end else if (soft_rst) begin
      mask_err_q  <= 1'b0;
      mask_done_q <= 1'b0;
      auto_seed_q <= 1'b0;
    end else if (ctl_wr) begin
      mask_err_q  <= wr_data[CTL_MERR];
      mask_done_q <= wr_data[CTL_MDONE];
      auto_seed_q <= wr_data[CTL_AUTO];
    end
  end

  rng_irq_gen irq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_evt (|op_done),
    .mask_done(mask_done_q),
    .clr      (clr_irq),
    .irq_o    (irq)
  );

  logic [31:0] lfsr_word;

  rng_lfsr #(.SEED(LFSR_SEED)) lfsr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (data_rd),
    .word_o(lfsr_word)
  );

  // Read path
  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (sel_ver)  rd_next = ID_WORD;
    if (sel_cmd)  rd_next = {30'b0, op_run[CMD_SEED], op_run[CMD_TEST]};
    if (sel_ctl)  rd_next = {25'b0, mask_err_q, mask_done_q, auto_seed_q, 4'b0};
    if (sel_stat) rd_next = status_word(op_fin[CMD_SEED], op_fin[CMD_TEST], busy_any);
    if (sel_data) rd_next = lfsr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/rng_ctl_chk.sv
module rng_ctl_chk
  import rng_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic [31:0]       rd_data,
  input logic              irq,
  input logic [1:0]        op_done,
  input logic [1:0]        op_go,
  input logic [1:0]        seed_st,
  input logic              soft_rst,
  input logic              clr_irq,
  input logic              mask_done,
  input logic [31:0]       lfsr_word
);
  logic mapped;
  assign mapped = (addr == ADDR_W'(OFS_VER)) || (addr == ADDR_W'(OFS_CMD)) ||
                  (addr == ADDR_W'(OFS_CTL)) || (addr == ADDR_W'(OFS_STAT)) ||
                  (addr == ADDR_W'(OFS_DATA));

  a_r3_seed_runs: assert property (@(posedge clk) disable iff (!rst_n)
    op_go[CMD_SEED] |=> (seed_st == 2'(OP_RUN)));

  a_r6_busy_xor_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(OFS_STAT)) |=> (rd_data[1] ^ rd_data[0]));

  a_r7_done_raises: assert property (@(posedge clk) disable iff (!rst_n)
    ((|op_done) && !mask_done) |=> irq);

  a_r7_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|op_done) && !mask_done));

  a_r8_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_irq && !(|op_done)) |=> !irq);

  a_r9_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !op_go[CMD_SEED]) |=> (seed_st == 2'(OP_IDLE)));

  a_r10_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_word != '0);

  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rd_data == '0));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind rng_ctl_top rng_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .irq      (irq),
  .op_done  (op_done),
  .op_go    (op_go),
  .seed_st  (op_st[1]),
  .soft_rst (soft_rst),
  .clr_irq  (clr_irq),
  .mask_done(mask_done_q),
  .lfsr_word(lfsr_word)
);

// File: tb/rng_ctl_top_tb_top.sv
module rng_ctl_top_tb_top;
  localparam int          SEED_C = 16;
  localparam int          TEST_C = 8;
  localparam logic [31:0] SEED0  = 32'hACE1_2D5F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  always #4 clk = ~clk;  // 125 MHz

  rng_ctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference model state
  int          m_seed_st, m_seed_left, m_test_st, m_test_left;  // 0 idle 1 run 2 done
  bit          m_merr, m_mdone, m_auto, m_irq;
  logic [31:0] m_lfsr, m_rd;

  function automatic logic [31:0] ref_next(input logic [31:0] s);
    logic fb;
    fb = ^(s & 32'h8020_0003);
    return (s << 1) | {31'b0, fb};
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] w;
    w = 32'h0;
    case (a)
      8'h00: w = 32'h1000_0240;
      8'h04: begin
        if (m_seed_st == 1) w = w + 2;
        if (m_test_st == 1) w = w + 1;
      end
      8'h08: w = (m_merr ? 32'h40 : 0) + (m_mdone ? 32'h20 : 0) + (m_auto ? 32'h10 : 0);
      8'h0C: begin
        w = 32'h5540;
        if (m_seed_st == 2) w = w + 32'h20;
        if (m_test_st == 2) w = w + 32'h10;
        if (m_seed_st == 1 || m_test_st == 1) w = w + 2; else w = w + 1;
      end
      8'h14: w = m_lfsr;
      default: w = 32'h0;
    endcase
    return w;
  endfunction

  task automatic m_op(inout int st, inout int left, input bit go, input bit clr,
                      input int cyc, output bit evt);
    evt = 1'b0;
    if (go) begin
      st = 1; left = cyc;
    end else if (clr) begin
      st = 0;
    end else if (st == 1) begin
      left = left - 1;
      if (left == 0) begin st = 2; evt = 1'b1; end
    end
  endtask

  task automatic m_edge(input logic [7:0] a, input bit we, input logic [31:0] wd, input bit re);
    bit is_cmd, srst, e1, e2, old_mask;
    is_cmd   = we && (a == 8'h04);
    srst     = is_cmd && wd[6];
    old_mask = m_mdone;
    if (re) m_rd = m_read(a);
    m_op(m_seed_st, m_seed_left, is_cmd && wd[1], srst, SEED_C, e1);
    m_op(m_test_st, m_test_left, is_cmd && wd[0], srst, TEST_C, e2);
    if (is_cmd && (wd[5] || wd[4])) m_irq = 1'b0;
    if ((e1 || e2) && !old_mask) m_irq = 1'b1;
    if (srst) begin
      m_merr = 0; m_mdone = 0; m_auto = 0;
    end else if (we && a == 8'h08) begin
      m_merr = wd[6]; m_mdone = wd[5]; m_auto = wd[4];
    end
    if (re && a == 8'h14) m_lfsr = ref_next(m_lfsr);
  endtask

  task automatic m_reset();
    m_seed_st = 0; m_seed_left = 0; m_test_st = 0; m_test_left = 0;
    m_merr = 0; m_mdone = 0; m_auto = 0; m_irq = 0;
    m_lfsr = SEED0; m_rd = 32'h0;
  endtask

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // One clock: drive, model the edge, compare outputs at the falling edge
  task automatic tick(input logic [7:0] a, input bit we, input logic [31:0] wd, input bit re);
    addr = a; wr_en = we; wr_data = wd; rd_en = re;
    @(posedge clk);
    m_edge(a, we, wd, re);
    @(negedge clk);
    check1("R7 irq vs model", irq, m_irq);
    check32("R12 rd_data vs model", rd_data, m_rd);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    tick(a, 1'b1, d, 1'b0);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    tick(a, 1'b0, 32'h0, 1'b1);
    check32(tag, rd_data, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(8'h00, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic hw_reset();
    addr = '0; wr_en = 0; wr_data = '0; rd_en = 0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    m_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] e;
    hw_reset();
    check1("R7 irq low after reset", irq, 1'b0);
    check32("R12 rd_data zero after reset", rd_data, 32'h0);

    rd_chk(8'h00, 32'h1000_0240, "R1 id word");
    rd_chk(8'h0C, 32'h0000_5541, "R5 idle status");
    rd_chk(8'h04, 32'h0, "R2 command idle");
    rd_chk(8'h08, 32'h0, "R4 control reset");

    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk(8'h08, 32'h70, "R4 control all ones");
    wr(8'h08, 32'h0);
    rd_chk(8'h08, 32'h0, "R4 control cleared");

    // Seed run length
    wr(8'h04, 32'h02);
    rd_chk(8'h04, 32'h2, "R2 seed running");
    rd_chk(8'h0C, 32'h5542, "R6 busy while seeding");
    idle(SEED_C - 3);
    check1("R3 seed still running", irq, 1'b0);
    idle(1);
    check1("R3 seed done on time", irq, 1'b1);
    rd_chk(8'h0C, 32'h5561, "R5 seed done status");
    wr(8'h04, 32'h10);
    check1("R8 clear via bit 4", irq, 1'b0);

    // Self-test, clear via bit 5
    wr(8'h04, 32'h01);
    idle(TEST_C);
    check1("R7 self-test raises irq", irq, 1'b1);
    rd_chk(8'h0C, 32'h5571, "R5 both done");
    wr(8'h04, 32'h20);
    check1("R8 clear via bit 5", irq, 1'b0);

    // Masked completion
    wr(8'h08, 32'h20);
    wr(8'h04, 32'h01);
    idle(TEST_C + 2);
    check1("R7 masked completion", irq, 1'b0);
    rd_chk(8'h0C, 32'h5571, "R7 masked op still done");
    wr(8'h08, 32'h0);

    // Restart reloads the count
    wr(8'h04, 32'h02);
    idle(5);
    wr(8'h04, 32'h02);
    idle(SEED_C - 1);
    check1("R3 restart reloads", irq, 1'b0);
    idle(1);
    check1("R3 restart completes", irq, 1'b1);
    wr(8'h04, 32'h10);

    // Both at once, then soft reset while running
    wr(8'h04, 32'h03);
    rd_chk(8'h04, 32'h3, "R2 both running");
    rd_chk(8'h0C, 32'h5542, "R6 busy both");
    wr(8'h08, 32'h70);
    wr(8'h04, 32'h40);
    rd_chk(8'h04, 32'h0, "R9 ops idle");
    rd_chk(8'h08, 32'h0, "R9 control cleared");
    rd_chk(8'h0C, 32'h5541, "R9 status idle");

    // Soft reset leaves a pending irq
    wr(8'h04, 32'h01);
    idle(TEST_C);
    check1("R7 irq before soft reset", irq, 1'b1);
    wr(8'h04, 32'h40);
    check1("R9 irq kept by soft reset", irq, 1'b1);
    wr(8'h04, 32'h10);

    // Soft reset with start in one write
    wr(8'h04, 32'h42);
    rd_chk(8'h04, 32'h2, "R9 start survives soft reset");
    idle(SEED_C);
    wr(8'h04, 32'h10);

    // Writes elsewhere have no effect
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h08, 32'h0, "R11 control untouched");
    rd_chk(8'h0C, 32'h5561, "R11 status untouched");
    rd_chk(8'h04, 32'h0, "R11 command untouched");
    rd_chk(8'h10, 32'h0, "R11 unmapped 0x10");
    rd_chk(8'h18, 32'h0, "R11 unmapped 0x18");
    rd_chk(8'h05, 32'h0, "R11 unmapped 0x05");
    rd_chk(8'hFC, 32'h0, "R11 unmapped 0xFC");

    // Random words
    e = SEED0;
    for (int i = 0; i < 4; i++) begin
      rd_chk(8'h14, e, "R10 generator word");
      e = ref_next(e);
    end
    idle(1);
    check32("R12 rd_data holds", rd_data, ref_next(ref_next(ref_next(SEED0))));
    hw_reset();
    check1("R7 irq low after second reset", irq, 1'b0);
    rd_chk(8'h14, SEED0, "R10 seed reloaded");
    rd_chk(8'h14, ref_next(SEED0), "R10 step after reload");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule